// File: doc/BRIEF.md
# Interrupt Event Queue Writer

This block turns an event-queue trigger into one entry in a circular buffer in system memory. A trigger carries a block number, a queue index and 31 bits of event data. The block looks the index up in a local table of eight-word queue descriptors. If the descriptor is valid and queueing is enabled, the block writes one 32-bit entry into the ring through a single-beat memory write port. It then advances the producer index, flips the generation bit when the ring wraps, and stores both back into the descriptor.

The ring has no consumer pointer. A reader finds new entries by comparing bit 31 of each entry with the generation it expects. After the memory step, the block decides whether to raise a processor notification. That decision depends on the descriptor's format bit, its priority field and its unconditional-notify bit. Software reads, writes and clears descriptors through a word-wide configuration port.

Triggers are accepted one at a time with a valid/ready handshake. Triggers addressed to another block number are discarded.

Top module: `evq_writer`

## Requirements
- R1: After reset, trig_ready is 1 and mem_req, ntf_valid and evq_err are 0. Every descriptor reads 0 in every word except word 1, which reads 0x5000_0000. Bit 30 is the notification-path Q bit and bit 28 is the escalation-path Q bit.
- R2: The written entry holds the descriptor's generation bit (word 1 bit 22) in bit 31 and event data bits 30..0 in bits 30..0. The entry is sent big-endian: mem_wdata[7:0] carries entry bits 31..24 (the byte at the lowest address), up to mem_wdata[31:24] carrying entry bits 7..0.
- R3: mem_addr equals the 60-bit base plus four times the producer index (word 1 bits 21..0). The base is word 2 bits 27..0 above all 32 bits of word 3.
- R4: After a completed write, the producer index becomes (index+1) modulo 2^(qsize+10), where qsize is word 0 bits 19..16. A qsize of 12 or more counts as 2^22 entries. When the index wraps to 0, generation bit 22 of word 1 toggles. All other bits of word 1 are kept.
- R5: A trigger is discarded when its block number differs from LOCAL_BLK or when the descriptor's valid bit (word 0 bit 31) is 0. A discarded trigger produces no memory request and no notification, and leaves the descriptor unchanged.
- R6: With enqueue (word 0 bit 30) clear, no memory write occurs and word 1 is unchanged, but the notification decision is still made.
- R7: With format (word 6 bit 23) equal to 0 and priority (word 7 bits 23..16) equal to 0xFF, no notification is produced.
- R8: With unconditional notify (word 0 bit 29) clear, no notification is produced.
- R9: A notification is a single-cycle ntf_valid pulse. It carries ntf_target = word 6 bits 18..0 and ntf_prio = word 7 bits 23..16. With format 1, a priority of 0xFF does not mask it.
- R10: If the memory write returns an error, word 1 is unchanged, evq_err pulses for exactly one cycle and no notification follows.
- R11: A cfg_clr pulse returns the selected descriptor to the reset contents of R1. A cfg_we pulse writes cfg_wdata to the selected word. cfg_rdata shows the selected word.
- R12: mem_req stays high with a stable mem_addr and mem_wdata until mem_ack. trig_ready is low from acceptance until the trigger has been fully handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger offered |
| trig_ready | output | 1 | Block can accept a trigger |
| trig_blk | input | BLK_W | Target block number |
| trig_idx | input | IDX_W | Descriptor index |
| trig_data | input | 31 | Event data |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 60 | Byte address of the entry |
| mem_wdata | output | 32 | Entry in big-endian byte order |
| mem_ack | input | 1 | Write completed |
| mem_err | input | 1 | Write failed (valid with mem_ack) |
| cfg_we | input | 1 | Write one descriptor word |
| cfg_clr | input | 1 | Reset one descriptor |
| cfg_idx | input | IDX_W | Descriptor selected by software |
| cfg_word | input | 3 | Word selected within the descriptor |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected descriptor word |
| ntf_valid | output | 1 | Notification pulse |
| ntf_target | output | 19 | Target processor index |
| ntf_prio | output | 8 | Notification priority |
| evq_err | output | 1 | Memory write error pulse |

## Verification
The main function is exercised with a table of descriptor setups. The cases cover:
- a mid-ring index, which checks the address and entry packing;
- an index just before the wrap, at generation 0 and at generation 1, which separates the index advance from the generation toggle;
- the smallest ring and a larger ring, which shows the modulus follows qsize;
- a qsize at the clamped top value, which exercises the widest index;
- enqueue off, priority masked under each format value, notify-enable off, and an invalid descriptor, which separate the gates on the write from the gates on the notification.

Directed tests then cover a foreign block number, a failing memory write, a slow acknowledge and a descriptor clear.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int WORD_W   = 32;
  localparam int NWORDS   = 8;
  localparam int PIDX_W   = 22;
  localparam int BASE_W   = 60;
  localparam int DATA_W   = 31;
  localparam int TGT_W    = 19;
  localparam int PRIO_W   = 8;
  localparam int QSZ_MIN_LG = 10;

  // word 0
  localparam int B_VALID  = 31;
  localparam int B_ENQ    = 30;
  localparam int B_UNOTE  = 29;
  localparam int B_QSZ_LO = 16;
  // word 1
  localparam int B_GEN    = 22;
  // word 6
  localparam int B_FMT    = 23;
  // word 7
  localparam int B_PRI_LO = 16;

  localparam logic [WORD_W-1:0] W1_RESET = 32'h5000_0000;
  localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;

  typedef logic [NWORDS-1:0][WORD_W-1:0] desc_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_WRITE = 2'd2,
    ST_NOTE  = 2'd3
  } evq_state_e;
endpackage

// File: rtl/evq_desc_table.sv
module evq_desc_table
  import evq_pkg::*;
#(
  parameter int NUM_DESC = 8,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_clr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [2:0]        cfg_word,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [WORD_W-1:0] upd_w1,
  input  logic [IDX_W-1:0]  rd_idx,
  output desc_t             rd_desc
);
  desc_t tbl_q [NUM_DESC];

  for (genvar d = 0; d < NUM_DESC; d++) begin : g_desc
    desc_t nxt;
    logic  en;
    always_comb begin
      nxt = tbl_q[d];
      en  = 1'b0;
      if (cfg_clr && cfg_idx == IDX_W'(d)) begin
        nxt    = '0;
        nxt[1] = W1_RESET;
        en     = 1'b1;
      end else if (cfg_we && cfg_idx == IDX_W'(d)) begin
        nxt[cfg_word] = cfg_wdata;
        en            = 1'b1;
      end else if (upd_en && upd_idx == IDX_W'(d)) begin
        nxt[1] = upd_w1;
        en     = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_q[d]    <= '0;
        tbl_q[d][1] <= W1_RESET;
      end else if (en) begin
        tbl_q[d] <= nxt;
      end
    end
  end

  assign cfg_rdata = tbl_q[cfg_idx][cfg_word];
  assign rd_desc   = tbl_q[rd_idx];
endmodule

// File: rtl/evq_ring_calc.sv
module evq_ring_calc
  import evq_pkg::*;
(
  input  logic [3:0]        qsize,
  input  logic [WORD_W-1:0] w1,
  input  logic [27:0]       base_hi,
  input  logic [WORD_W-1:0] base_lo,
  input  logic [DATA_W-1:0] data,
  output logic [BASE_W-1:0] addr,
  output logic [WORD_W-1:0] wdata_be,
  output logic [WORD_W-1:0] next_w1
);
  localparam int LG_W = $clog2(PIDX_W + 1);

  logic [LG_W-1:0]   lg;
  logic [PIDX_W-1:0] mask, idx, nidx;
  logic [WORD_W-1:0] entry;
  logic              gen, wrap;

  always_comb begin
    idx  = w1[PIDX_W-1:0];
    gen  = w1[B_GEN];
    lg   = (int'(qsize) + QSZ_MIN_LG >= PIDX_W) ? LG_W'(PIDX_W)
                                                : LG_W'(int'(qsize) + QSZ_MIN_LG);
    mask = (lg == LG_W'(PIDX_W)) ? '1 : ((PIDX_W'(1) << lg) - PIDX_W'(1));
    nidx = (idx + PIDX_W'(1)) & mask;
    wrap = (nidx == '0);
    next_w1 = w1;
    next_w1[PIDX_W-1:0] = nidx;
    next_w1[B_GEN]      = gen ^ wrap;
    entry = {gen, data};
    addr  = {base_hi, base_lo} + {{(BASE_W-PIDX_W-2){1'b0}}, idx, 2'b00};
  end

  for (genvar b = 0; b < 4; b++) begin : g_swap
    assign wdata_be[8*b +: 8] = entry[8*(3-b) +: 8];
  end
endmodule

// File: rtl/evq_notify_dec.sv
module evq_notify_dec
  import evq_pkg::*;
(
  input  logic              uncond,
  input  logic              fmt,
  input  logic [PRIO_W-1:0] prio,
  output logic              fire
);
  logic masked;
  assign masked = !fmt && (prio == PRIO_OFF);
  assign fire   = uncond && !masked;
endmodule

// File: rtl/evq_writer.sv
module evq_writer
  import evq_pkg::*;
#(
  parameter int NUM_DESC  = 8,
  parameter int BLK_W     = 4,
  parameter int LOCAL_BLK = 0,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [BLK_W-1:0]  trig_blk,
  input  logic [IDX_W-1:0]  trig_idx,
  input  logic [30:0]       trig_data,
  output logic              mem_req,
  output logic [59:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              cfg_we,
  input  logic              cfg_clr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [2:0]        cfg_word,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              ntf_valid,
  output logic [18:0]       ntf_target,
  output logic [7:0]        ntf_prio,
  output logic              evq_err
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  evq_state_e        st_q, st_d;
  logic [BLK_W-1:0]  blk_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic              cap_en;
  desc_t             dsc;
  logic              upd_en, fire, hit;
  logic [WORD_W-1:0] next_w1;
  logic              ntf_d, err_d;

  evq_desc_table #(.NUM_DESC(NUM_DESC)) u_tbl (
    .clk, .rst_n(rst_q),
    .cfg_we, .cfg_clr, .cfg_idx, .cfg_word, .cfg_wdata, .cfg_rdata,
    .upd_en, .upd_idx(idx_q), .upd_w1(next_w1),
    .rd_idx(idx_q), .rd_desc(dsc)
  );

  evq_ring_calc u_ring (
    .qsize(dsc[0][B_QSZ_LO +: 4]), .w1(dsc[1]),
    .base_hi(dsc[2][27:0]), .base_lo(dsc[3]),
    .data(data_q), .addr(mem_addr), .wdata_be(mem_wdata), .next_w1(next_w1)
  );

  evq_notify_dec u_ntf (
    .uncond(dsc[0][B_UNOTE]), .fmt(dsc[6][B_FMT]),
    .prio(dsc[7][B_PRI_LO +: PRIO_W]), .fire(fire)
  );

  assign hit        = (blk_q == BLK_W'(LOCAL_BLK)) && dsc[0][B_VALID];
  assign trig_ready = (st_q == ST_IDLE);
  assign mem_req    = (st_q == ST_WRITE);
  assign cap_en     = trig_ready && trig_valid;

  always_comb begin
    st_d   = st_q;
    upd_en = 1'b0;
    ntf_d  = 1'b0;
    err_d  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (trig_valid) st_d = ST_LOOK;
      ST_LOOK: begin
        if (!hit)                 st_d = ST_IDLE;
        else if (dsc[0][B_ENQ])   st_d = ST_WRITE;
        else                      st_d = ST_NOTE;
      end
      ST_WRITE: if (mem_ack) begin
        err_d  = mem_err;
        upd_en = !mem_err;
        st_d   = mem_err ? ST_IDLE : ST_NOTE;
      end
      ST_NOTE: begin
        ntf_d = fire;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q       <= ST_IDLE;
      ntf_valid  <= 1'b0;
      evq_err    <= 1'b0;
      ntf_target <= '0;
      ntf_prio   <= '0;
    end else begin
      st_q      <= st_d;
      ntf_valid <= ntf_d;
      evq_err   <= err_d;
      if (ntf_d) begin
        ntf_target <= dsc[6][TGT_W-1:0];
        ntf_prio   <= dsc[7][B_PRI_LO +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      blk_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      blk_q  <= trig_blk;
      idx_q  <= trig_idx;
      data_q <= trig_data;
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_q)
    mem_req |-> !trig_ready);
  // R9
  ntf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ntf_valid |=> !ntf_valid);
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    evq_err |=> (!evq_err && !ntf_valid));
  // R5
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == ST_LOOK && !hit) |=> (!mem_req && trig_ready));
endmodule

// File: tb/evq_writer_tb.sv
module evq_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic [3:0]  trig_blk = '0;
  logic [2:0]  trig_idx = '0;
  logic [30:0] trig_data = '0;
  logic        mem_req;
  logic [59:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic        cfg_we = 1'b0, cfg_clr = 1'b0;
  logic [2:0]  cfg_idx = '0, cfg_word = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ntf_valid;
  logic [18:0] ntf_target;
  logic [7:0]  ntf_prio;
  logic        evq_err;

  always #4 clk = ~clk;

  evq_writer u_dut (.*);

  int errs = 0, checks = 0;
  int wr_cnt = 0, ntf_cnt = 0, err_cnt = 0, stab_fail = 0, req_cycles = 0;
  int ack_lat = 0;
  bit err_mode = 0;
  logic [59:0] last_addr, first_addr;
  logic [31:0] last_data;
  logic [18:0] last_tgt;
  logic [7:0]  last_prio;

  localparam logic [59:0] BASE = 60'h0ABC_1000_0000;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and output monitor
  always @(negedge clk) begin
    if (ntf_valid) begin ntf_cnt++; last_tgt = ntf_target; last_prio = ntf_prio; end
    if (evq_err) err_cnt++;
    if (mem_ack) begin
      mem_ack = 1'b0; mem_err = 1'b0; req_cycles = 0;
    end else if (mem_req) begin
      if (req_cycles == 0) first_addr = mem_addr;
      else if (mem_addr != first_addr) stab_fail++;
      req_cycles++;
      if (req_cycles > ack_lat) begin
        mem_ack = 1'b1; mem_err = err_mode;
        last_addr = mem_addr; last_data = mem_wdata;
        if (!err_mode) wr_cnt++;
      end
    end
  end

  task automatic cfg_write(input logic [2:0] idx, input logic [2:0] w, input logic [31:0] v);
    @(negedge clk);
    cfg_idx = idx; cfg_word = w; cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] idx, input logic [2:0] w, output logic [31:0] v);
    @(negedge clk);
    cfg_idx = idx; cfg_word = w;
    #1 v = cfg_rdata;
  endtask

  task automatic setup(input logic [31:0] w0, w1, w6, w7);
    cfg_write(3'd2, 3'd0, w0);
    cfg_write(3'd2, 3'd1, w1);
    cfg_write(3'd2, 3'd2, 32'h0000_0ABC);
    cfg_write(3'd2, 3'd3, 32'h1000_0000);
    cfg_write(3'd2, 3'd6, w6);
    cfg_write(3'd2, 3'd7, w7);
  endtask

  task automatic fire(input logic [3:0] blk, input logic [30:0] d);
    @(negedge clk);
    trig_blk = blk; trig_idx = 3'd2; trig_data = d; trig_valid = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0;
    chk(trig_ready == 1'b0, "R12 ready low after accept", trig_ready, 0);
    while (!trig_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] w0, w1, w6, w7, dat, xw1;
    logic        xwr, xntf;
  } vec_t;

  localparam vec_t VEC [11] = '{
    // R2 R3 mid-ring
    '{32'hE000_0000, 32'h5000_0005, 32'h0000_1234, 32'h0003_0000, 32'h8765_4321, 32'h5000_0006, 1'b1, 1'b1},
    // R4 wrap gen0 -> gen1
    '{32'hE000_0000, 32'h5000_03FF, 32'h0000_0001, 32'h0000_0000, 32'h0000_00AA, 32'h5040_0000, 1'b1, 1'b1},
    // R4 wrap gen1 -> gen0
    '{32'hE000_0000, 32'h5040_03FF, 32'h0000_0002, 32'h0007_0000, 32'h0000_0001, 32'h5000_0000, 1'b1, 1'b1},
    // R4 qsize 4 no wrap at 1024
    '{32'hE004_0000, 32'h5000_03FF, 32'h0000_0003, 32'h0001_0000, 32'h1234_5678, 32'h5000_0400, 1'b1, 1'b1},
    // R4 qsize 4 wrap at 16384
    '{32'hE004_0000, 32'h5000_3FFF, 32'h0000_0004, 32'h0001_0000, 32'h0000_0055, 32'h5040_0000, 1'b1, 1'b1},
    // R4 qsize 15 clamped to 2^22
    '{32'hE00F_0000, 32'h503F_FFFF, 32'h0000_0005, 32'h0002_0000, 32'h7FFF_FFFF, 32'h5040_0000, 1'b1, 1'b1},
    // R6 enqueue off
    '{32'hA000_0000, 32'h5000_0007, 32'h0000_0006, 32'h0005_0000, 32'h0000_0077, 32'h5000_0007, 1'b0, 1'b1},
    // R7 masked, format 0
    '{32'hE000_0000, 32'h5000_0010, 32'h0000_0007, 32'h00FF_0000, 32'h0000_0011, 32'h5000_0011, 1'b1, 1'b0},
    // R9 format 1 ignores 0xFF
    '{32'hE000_0000, 32'h5000_0020, 32'h0087_FFFF, 32'h00FF_0000, 32'h0000_0022, 32'h5000_0021, 1'b1, 1'b1},
    // R8 unconditional notify off
    '{32'hC000_0000, 32'h5000_0030, 32'h0000_0008, 32'h0004_0000, 32'h0000_0033, 32'h5000_0031, 1'b1, 1'b0},
    // R5 invalid descriptor
    '{32'h6000_0000, 32'h5000_0040, 32'h0000_0009, 32'h0004_0000, 32'h0000_0044, 32'h5000_0040, 1'b0, 1'b0}
  };

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(trig_ready && !mem_req && !ntf_valid && !evq_err, "R1 outputs idle",
        {trig_ready, mem_req, ntf_valid, evq_err}, 4'b1000);
    cfg_read(3'd5, 3'd1, rv);
    chk(rv == 32'h5000_0000, "R1 word1 reset", rv, 32'h5000_0000);
    cfg_read(3'd5, 3'd0, rv);
    chk(rv == 32'h0, "R1 word0 reset", rv, 0);

    for (int i = 0; i < 11; i++) begin
      vec_t v;
      int w0c, n0c;
      logic [31:0] ent, xdat;
      logic [59:0] xaddr;
      v = VEC[i];
      setup(v.w0, v.w1, v.w6, v.w7);
      w0c = wr_cnt; n0c = ntf_cnt;
      fire(4'd0, v.dat[30:0]);
      chk((wr_cnt - w0c) == int'(v.xwr), $sformatf("R5/R6 write count vec%0d", i), wr_cnt - w0c, v.xwr);
      if (v.xwr) begin
        xaddr = BASE + {36'b0, v.w1[21:0], 2'b00};
        chk(last_addr == xaddr, $sformatf("R3 addr vec%0d", i), last_addr, xaddr);
        ent  = {v.w1[22], v.dat[30:0]};
        xdat = {ent[7:0], ent[15:8], ent[23:16], ent[31:24]};
        chk(last_data == xdat, $sformatf("R2 entry vec%0d", i), last_data, xdat);
      end
      cfg_read(3'd2, 3'd1, rv);
      chk(rv == v.xw1, $sformatf("R4 word1 vec%0d", i), rv, v.xw1);
      chk((ntf_cnt - n0c) == int'(v.xntf), $sformatf("R7/R8/R9 notify count vec%0d", i), ntf_cnt - n0c, v.xntf);
      if (v.xntf) begin
        chk(last_tgt == v.w6[18:0] && last_prio == v.w7[23:16], $sformatf("R9 target/prio vec%0d", i),
            {last_tgt, last_prio}, {v.w6[18:0], v.w7[23:16]});
      end
    end

    // R5 foreign block number
    begin
      int w0c, n0c;
      setup(32'hE000_0000, 32'h5000_0003, 32'h0000_0001, 32'h0001_0000);
      w0c = wr_cnt; n0c = ntf_cnt;
      fire(4'd3, 31'h5);
      cfg_read(3'd2, 3'd1, rv);
      chk(wr_cnt == w0c && ntf_cnt == n0c && rv == 32'h5000_0003, "R5 foreign block",
          {wr_cnt - w0c, ntf_cnt - n0c, rv}, 32'h5000_0003);
    end

    // R10 memory error
    begin
      int n0c, e0c;
      setup(32'hE000_0000, 32'h5000_03FF, 32'h0000_0001, 32'h0001_0000);
      n0c = ntf_cnt; e0c = err_cnt;
      err_mode = 1;
      fire(4'd0, 31'h9);
      err_mode = 0;
      cfg_read(3'd2, 3'd1, rv);
      chk(rv == 32'h5000_03FF, "R10 word1 kept", rv, 32'h5000_03FF);
      chk(err_cnt - e0c == 1, "R10 one error pulse", err_cnt - e0c, 1);
      chk(ntf_cnt == n0c, "R10 no notify", ntf_cnt - n0c, 0);
    end

    // R12 slow acknowledge
    begin
      int s0;
      s0 = stab_fail;
      setup(32'hE000_0000, 32'h5000_0008, 32'h0000_0001, 32'h0001_0000);
      ack_lat = 5;
      fire(4'd0, 31'h1);
      ack_lat = 0;
      chk(stab_fail == s0, "R12 address stable while waiting", stab_fail - s0, 0);
      cfg_read(3'd2, 3'd1, rv);
      chk(rv == 32'h5000_0009, "R12 write completes after delay", rv, 32'h5000_0009);
    end

    // R11 descriptor clear
    cfg_write(3'd2, 3'd7, 32'hDEAD_BEEF);
    cfg_read(3'd2, 3'd7, rv);
    chk(rv == 32'hDEAD_BEEF, "R11 word write", rv, 32'hDEAD_BEEF);
    @(negedge clk);
    cfg_idx = 3'd2; cfg_clr = 1'b1;
    @(negedge clk);
    cfg_clr = 1'b0;
    cfg_read(3'd2, 3'd1, rv);
    chk(rv == 32'h5000_0000, "R11 clear word1", rv, 32'h5000_0000);
    cfg_read(3'd2, 3'd0, rv);
    chk(rv == 32'h0, "R11 clear word0", rv, 0);
    cfg_read(3'd2, 3'd7, rv);
    chk(rv == 32'h0, "R11 clear word7", rv, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule